// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block is a small instruction store that keeps only the opening instructions of branch destinations. It is meant for fetch units that can sustain one instruction per clock once a sequential burst is under way, but lose several clocks when a branch forces a fresh address out to memory. On a taken branch whose destination is held, the block streams the stored words to the pipeline, one per clock. At the same time it reports the address just past the stored block, so that the external fetch can start there and catch up by the time the last stored word is used.

A taken branch to a destination that is not held claims a slot in round-robin order. The next four instruction words that memory returns are written into that slot. The slot only starts to answer lookups once all four words are in. Words that memory returns as part of ordinary sequential fetching are never kept. A flush input empties the whole store in a single clock.

The default size is 32 slots of four 32-bit words, which is 512 bytes in total. Lookup is fully associative over the slots.

Top module: `branch_target_cache`

## Requirements
- R1: When `br_valid` is high in cycle T (and `flush` is low), `hit` is high in cycle T+1 exactly when a valid slot's tag equals the full `br_addr`. `hit` is low in every cycle that does not follow such a branch.
- R2: On a hit, `inst_valid` is high in cycles T+1 to T+4 and `inst_data` carries, in that order, the stored words for addresses `br_addr`, +4, +8 and +12. `inst_valid` is low in T+5 unless another branch hits.
- R3: On a hit, `pf_addr` in cycle T+1 equals `br_addr + 16`, the byte address of the fifth instruction.
- R4: A taken branch that misses allocates a slot. The following four cycles with `fill_valid` high (gaps allowed) write that slot's words in address order. The slot gives no hit until the fourth word has been written.
- R5: `fill_valid` words that arrive while no allocation is pending are discarded. Stored slots keep their contents.
- R6: Slots are claimed in round-robin order starting at slot 0. With N slots, the (N+1)-th allocation evicts the destination of the first, while the others still hit.
- R7: `flush` clears every slot in one cycle and cancels any pending fill and any stream in progress. A branch in the flush cycle is ignored: no hit and no allocation. `hit` and `inst_valid` are low in the next cycle.
- R8: A taken branch that arrives before a pending fill has received four words abandons that fill. Later `fill_valid` words are not credited to it, and the abandoned slot never hits.
- R9: A taken branch during a stream ends that stream at once. On a hit, the new destination's words follow from cycle T+1. On a miss, `inst_valid` is low from T+1.
- R10: After reset, `hit` and `inst_valid` are low and every slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties all slots in one cycle |
| br_valid | input | 1 | Taken branch this cycle |
| br_addr | input | ADDR_W | Branch destination byte address |
| fill_valid | input | 1 | Instruction word returned by memory this cycle |
| fill_data | input | DATA_W | Returned instruction word |
| hit | output | 1 | Destination of the previous cycle's branch was held |
| pf_addr | output | ADDR_W | Address where the external fetch should start after a hit |
| inst_valid | output | 1 | `inst_data` carries a stored instruction |
| inst_data | output | DATA_W | Streamed stored instruction |

## Verification
The bench first sweeps more destinations than there are slots, with and without gaps between fill words, so that round-robin eviction is exercised. A pointer that fails to wrap or skips slots would evict the wrong destination and produce an unexpected hit or miss. It then goes after the partial-fill cases. A slot validated too early would hit with stale words, and a fill that is not abandoned on a new branch would let stray words complete it. Stray sequential words are also sent while no fill is pending, which catches a design that overwrites stored slots. Finally, branches are placed inside running streams and in the same cycle as a flush, which catches streams that run past four words, fail to restart, or outlive a miss or a flush.

// File: rtl/btc_pkg.sv
package btc_pkg;
  localparam int unsigned INSN_BYTES = 4;

  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_BUSY = 1'b1
  } fill_state_e;
endpackage

// File: rtl/btc_tag_array.sv
module btc_tag_array #(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [IDX_W-1:0] lk_idx,
  input  logic             alloc_en,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic [TAG_W-1:0] alloc_tag,
  input  logic             commit_en,
  input  logic [IDX_W-1:0] commit_idx
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ENTRIES-1:0] match;

  // valid bits: cleared on allocation, set once the slot is full
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
    end else begin
      if (alloc_en)  valid_q[alloc_idx]  <= 1'b0;
      if (commit_en) valid_q[commit_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) tag_q[alloc_idx] <= alloc_tag;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign match[e] = valid_q[e] && (tag_q[e] == lk_tag);
  end

  always_comb begin
    lk_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (match[e]) lk_idx = IDX_W'(e);
    end
    lk_hit = |match;
  end
endmodule

// File: rtl/btc_data_ram.sv
module btc_data_ram #(
  parameter int DEPTH  = 128,
  parameter int DATA_W = 32,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/branch_target_cache.sv
module branch_target_cache
  import btc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 32,
  parameter int WORDS   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              br_valid,
  input  logic [ADDR_W-1:0] br_addr,
  input  logic              fill_valid,
  input  logic [DATA_W-1:0] fill_data,
  output logic              hit,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              inst_valid,
  output logic [DATA_W-1:0] inst_data
);
  localparam int IDX_W       = $clog2(ENTRIES);
  localparam int WORD_W      = $clog2(WORDS);
  localparam int RAM_AW      = IDX_W + WORD_W;
  localparam int BLOCK_BYTES = WORDS * INSN_BYTES;
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WORDS - 1);

  logic              lk_hit;
  logic [IDX_W-1:0]  lk_idx;
  logic              take_br, hit_now, miss_now;

  logic [IDX_W-1:0]  rr_q;
  fill_state_e       fill_st_q;
  logic [IDX_W-1:0]  fill_idx_q;
  logic [WORD_W-1:0] fill_cnt_q;
  logic              fill_write, fill_last;

  logic              str_busy_q;
  logic [IDX_W-1:0]  str_idx_q;
  logic [WORD_W-1:0] str_cnt_q;
  logic [RAM_AW-1:0] rd_addr;

  logic              hit_q, inst_valid_q;
  logic [ADDR_W-1:0] pf_q;

  assign take_br    = br_valid && !flush;
  assign hit_now    = take_br && lk_hit;
  assign miss_now   = take_br && !lk_hit;
  assign fill_write = (fill_st_q == FILL_BUSY) && fill_valid && !take_br && !flush;
  assign fill_last  = fill_write && (fill_cnt_q == LAST_WORD);
  assign rd_addr    = hit_now ? {lk_idx, {WORD_W{1'b0}}} : {str_idx_q, str_cnt_q};

  btc_tag_array #(
    .ENTRIES(ENTRIES),
    .TAG_W  (ADDR_W)
  ) u_tags (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .lk_tag    (br_addr),
    .lk_hit    (lk_hit),
    .lk_idx    (lk_idx),
    .alloc_en  (miss_now),
    .alloc_idx (rr_q),
    .alloc_tag (br_addr),
    .commit_en (fill_last),
    .commit_idx(fill_idx_q)
  );

  btc_data_ram #(
    .DEPTH (ENTRIES * WORDS),
    .DATA_W(DATA_W)
  ) u_ram (
    .clk  (clk),
    .we   (fill_write),
    .waddr({fill_idx_q, fill_cnt_q}),
    .wdata(fill_data),
    .raddr(rd_addr),
    .rdata(inst_data)
  );

  // allocation and fill tracking
  always_ff @(posedge clk) begin
    if (rst) begin
      rr_q       <= '0;
      fill_st_q  <= FILL_IDLE;
      fill_idx_q <= '0;
      fill_cnt_q <= '0;
    end else if (flush) begin
      fill_st_q <= FILL_IDLE;
    end else if (miss_now) begin
      fill_st_q  <= FILL_BUSY;
      fill_idx_q <= rr_q;
      fill_cnt_q <= '0;
      rr_q       <= rr_q + 1'b1;
    end else if (hit_now) begin
      fill_st_q <= FILL_IDLE;
    end else if (fill_write) begin
      fill_cnt_q <= fill_cnt_q + 1'b1;
      if (fill_last) fill_st_q <= FILL_IDLE;
    end
  end

  // stream sequencing over the stored words
  always_ff @(posedge clk) begin
    if (rst) begin
      str_busy_q <= 1'b0;
      str_idx_q  <= '0;
      str_cnt_q  <= '0;
    end else if (flush || miss_now) begin
      str_busy_q <= 1'b0;
    end else if (hit_now) begin
      str_busy_q <= 1'b1;
      str_idx_q  <= lk_idx;
      str_cnt_q  <= WORD_W'(1);
    end else if (str_busy_q) begin
      str_cnt_q <= str_cnt_q + 1'b1;
      if (str_cnt_q == LAST_WORD) str_busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q        <= 1'b0;
      inst_valid_q <= 1'b0;
      pf_q         <= '0;
    end else begin
      hit_q        <= hit_now;
      inst_valid_q <= hit_now || (str_busy_q && !take_br && !flush);
      if (hit_now) pf_q <= br_addr + ADDR_W'(BLOCK_BYTES);
    end
  end

  assign hit        = hit_q;
  assign inst_valid = inst_valid_q;
  assign pf_addr    = pf_q;
endmodule

// File: rtl/btc_checks.sv
module btc_checks #(
  parameter int ADDR_W = 32,
  parameter int WORDS  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              br_valid,
  input logic [ADDR_W-1:0] br_addr,
  input logic              hit,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              inst_valid
);
  localparam int RUN_W = $clog2(WORDS) + 2;
  localparam int BLOCK_BYTES = WORDS * 4;

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst)             run_q <= '0;
    else if (hit)        run_q <= RUN_W'(1);
    else if (inst_valid) run_q <= run_q + 1'b1;
    else                 run_q <= '0;
  end

  // R1: a hit only follows a taken, unflushed branch
  a_r1_hit_needs_branch: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($past(br_valid) && !$past(flush)));

  // R2: a hit starts a stream
  a_r2_stream_starts: assert property (@(posedge clk) disable iff (rst)
    hit |-> inst_valid);

  // R2: a stream never exceeds the block length
  a_r2_stream_bounded: assert property (@(posedge clk) disable iff (rst)
    (inst_valid && !hit) |-> (run_q != '0 && run_q < RUN_W'(WORDS)));

  // R3: prefetch points past the stored block
  a_r3_prefetch_addr: assert property (@(posedge clk) disable iff (rst)
    hit |-> (pf_addr == $past(br_addr) + ADDR_W'(BLOCK_BYTES)));

  // R7: flush silences the outputs in the next cycle
  a_r7_flush_quiet: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!hit && !inst_valid));

  // R9: a missing branch ends any stream
  a_r9_miss_ends_stream: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !flush) |=> (hit || !inst_valid));
endmodule

bind branch_target_cache btc_checks #(
  .ADDR_W(ADDR_W),
  .WORDS (WORDS)
) u_btc_checks (
  .clk       (clk),
  .rst       (rst),
  .flush     (flush),
  .br_valid  (br_valid),
  .br_addr   (br_addr),
  .hit       (hit),
  .pf_addr   (pf_addr),
  .inst_valid(inst_valid)
);

// File: tb/branch_target_cache_bench.sv
`timescale 1ns/1ps
module branch_target_cache_bench;
  localparam int NE = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        br_valid = 1'b0;
  logic [31:0] br_addr = '0;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_data = '0;
  logic        hit;
  logic [31:0] pf_addr;
  logic        inst_valid;
  logic [31:0] inst_data;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // model state derived from the requirements
  logic [31:0] m_tag [NE];
  bit          m_valid [NE];
  int          m_ptr = 0;
  bit          p_active = 1'b0;
  int          p_idx = 0;
  int          p_cnt = 0;

  always #2.5 clk = ~clk;

  branch_target_cache #(
    .ADDR_W(32), .DATA_W(32), .ENTRIES(NE), .WORDS(4)
  ) u_branch_target_cache (
    .clk(clk), .rst(rst), .flush(flush), .br_valid(br_valid), .br_addr(br_addr),
    .fill_valid(fill_valid), .fill_data(fill_data), .hit(hit), .pf_addr(pf_addr),
    .inst_valid(inst_valid), .inst_data(inst_data)
  );

  function automatic logic [31:0] word_of(logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h1357_2468;
  endfunction

  function automatic int m_lookup(logic [31:0] a);
    for (int e = 0; e < NE; e++) if (m_valid[e] && m_tag[e] == a) return e;
    return -1;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic model_branch(logic [31:0] a, int idx);
    p_active = 1'b0;
    if (idx < 0) begin
      m_valid[m_ptr] = 1'b0;
      m_tag[m_ptr]   = a;
      p_active = 1'b1;
      p_idx    = m_ptr;
      p_cnt    = 0;
      m_ptr    = (m_ptr + 1) % NE;
    end
  endtask

  // branch, then check hit, prefetch and the whole stream
  task automatic probe(logic [31:0] a, string req);
    int idx = m_lookup(a);
    @(negedge clk); br_valid = 1'b1; br_addr = a;
    @(negedge clk); br_valid = 1'b0;
    model_branch(a, idx);
    check(hit == (idx >= 0), req, "hit", 32'(hit), 32'(idx >= 0));
    if (idx >= 0) begin
      check(pf_addr == a + 32'd16, req, "pf_addr", pf_addr, a + 32'd16);
      for (int k = 0; k < 4; k++) begin
        check(inst_valid && inst_data == word_of(a + 32'(4 * k)), req, "stream word",
              inst_data, word_of(a + 32'(4 * k)));
        @(negedge clk);
      end
      check(!inst_valid, req, "stream end", 32'(inst_valid), 32'd0);
    end else begin
      check(!inst_valid, req, "no stream on miss", 32'(inst_valid), 32'd0);
    end
  endtask

  task automatic feed(logic [31:0] a, int n, int start, int gap, bit junk);
    for (int k = start; k < start + n; k++) begin
      @(negedge clk);
      fill_valid = 1'b1;
      fill_data  = junk ? ~word_of(a + 32'(4 * k)) : word_of(a + 32'(4 * k));
      if (p_active) begin
        p_cnt++;
        if (p_cnt == 4) begin
          m_valid[p_idx] = 1'b1;
          p_active = 1'b0;
        end
      end
      for (int g = 0; g < gap; g++) begin
        @(negedge clk); fill_valid = 1'b0;
      end
    end
    @(negedge clk); fill_valid = 1'b0;
  endtask

  task automatic do_flush(bit with_br, logic [31:0] a);
    @(negedge clk); flush = 1'b1; br_valid = with_br; br_addr = a;
    @(negedge clk); flush = 1'b0; br_valid = 1'b0;
    for (int e = 0; e < NE; e++) m_valid[e] = 1'b0;
    p_active = 1'b0;
    check(!hit, "R7", "hit after flush", 32'(hit), 32'd0);
    check(!inst_valid, "R7", "inst_valid after flush", 32'(inst_valid), 32'd0);
  endtask

  function automatic logic [31:0] tgt(int i);
    return 32'h0000_1000 + 32'(i) * 32'h104;
  endfunction

  initial begin
    for (int e = 0; e < NE; e++) begin m_valid[e] = 1'b0; m_tag[e] = '0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!hit, "R10", "hit after reset", 32'(hit), 32'd0);
    check(!inst_valid, "R10", "inst_valid after reset", 32'(inst_valid), 32'd0);

    // allocate all slots, alternating fill gaps
    for (int i = 0; i < NE; i++) begin
      probe(tgt(i), "R10");
      feed(tgt(i), 4, 0, i % 2, 1'b0);
    end
    for (int i = 0; i < NE; i++) probe(tgt(i), "R1");

    // stray sequential words must not be stored
    feed(32'h0000_9000, 6, 0, 0, 1'b1);
    for (int i = 0; i < NE; i++) probe(tgt(i), "R5");

    // stream replaced by a hitting branch
    @(negedge clk); br_valid = 1'b1; br_addr = tgt(0);
    @(negedge clk); br_addr = tgt(1);
    check(inst_valid && inst_data == word_of(tgt(0)), "R9", "first stream word", inst_data, word_of(tgt(0)));
    @(negedge clk); br_valid = 1'b0;
    check(hit && pf_addr == tgt(1) + 32'd16, "R9", "restart pf_addr", pf_addr, tgt(1) + 32'd16);
    for (int k = 0; k < 4; k++) begin
      check(inst_valid && inst_data == word_of(tgt(1) + 32'(4 * k)), "R9", "restarted word",
            inst_data, word_of(tgt(1) + 32'(4 * k)));
      @(negedge clk);
    end
    check(!inst_valid, "R9", "restarted stream end", 32'(inst_valid), 32'd0);
    p_active = 1'b0;

    // stream ended by a missing branch
    @(negedge clk); br_valid = 1'b1; br_addr = tgt(2);
    @(negedge clk); br_addr = tgt(7);
    check(inst_valid && inst_data == word_of(tgt(2)), "R9", "word before miss", inst_data, word_of(tgt(2)));
    @(negedge clk); br_valid = 1'b0;
    check(!hit && !inst_valid, "R9", "stream after miss", 32'(inst_valid), 32'd0);
    model_branch(tgt(7), -1);
    feed(tgt(7), 4, 0, 0, 1'b0);
    probe(tgt(7), "R6");

    // partial fill is not visible, then completes elsewhere
    probe(tgt(8), "R4");
    feed(tgt(8), 3, 0, 0, 1'b0);
    probe(tgt(8), "R4");
    feed(tgt(8), 4, 0, 1, 1'b0);
    probe(tgt(8), "R4");

    // abandoned fill never completes
    probe(tgt(9), "R8");
    feed(tgt(9), 2, 0, 0, 1'b0);
    probe(tgt(8), "R8");
    feed(tgt(9), 2, 2, 0, 1'b0);
    probe(tgt(9), "R8");
    feed(tgt(9), 4, 0, 0, 1'b0);

    // flush with a branch in the same cycle, then everything misses
    do_flush(1'b1, tgt(8));
    probe(tgt(8), "R7");
    feed(tgt(8), 2, 0, 0, 1'b0);
    do_flush(1'b0, 32'h0);
    feed(tgt(8), 2, 2, 0, 1'b0);
    probe(tgt(8), "R7");
    feed(tgt(8), 4, 0, 0, 1'b0);

    // round-robin sweep over more destinations than slots
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < NE + 2; i++) begin
        probe(tgt(20 + i), "R6");
        if (!m_valid[(m_ptr + NE - 1) % NE] && p_active) feed(tgt(20 + i), 4, 0, r, 1'b0);
      end
      for (int i = 0; i < NE + 2; i++) probe(tgt(20 + i), "R6");
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end
endmodule